// File: doc/BRIEF.md
# Flash Protection Lockdown and Update Sequencer

This block is a host-side controller that walks a serial flash device through two fixed command programmes used to lock its memory array behind a 64-bit password. Each command leaves the block as a single-cycle strobe carrying an opcode, an address and a data word. A physical bus engine outside the block turns these strobes into serial traffic. For read-type commands, that engine returns a response word.

In lockdown mode, the block protects every sector held in its small sector register file. It then programs the password and reads the password back. If the readback matches, it commits the irreversible switch to password mode. In update mode, the block first records the protection byte of every listed sector. It then unlocks with the password, erases all protection bits, and waits for the host to signal that the array update is finished. After that signal it protects again the sectors that were protected before, and it locks the protection bits once more.

Every program-type command is followed by status polling. The polling is bounded, so a device that stays busy ends the run with an error instead of hanging the sequencer.

Top module: `lockseq_top`

## Requirements
- R1: In lockdown mode, for each listed sector in index order, the block issues write-enable (06h), then protection program (FDh) with that sector's address, then status reads (05h) until a response has bit 0 (busy) clear. Commands not tied to a sector carry address 0, and commands with no payload carry data 0.
- R2: Once all sectors are done, lockdown issues write-enable, then password program (E8h) with the 64-bit password as data, then polls status, then issues password read (E7h) and compares the full 64-bit response with the password.
- R3: On a matching readback, lockdown issues write-enable, then mode write (2Fh) with data FFFBh, then polls status, and then raises done. Lockdown issues no lock-bit clear command.
- R4: On a mismatching readback, the block raises error and issues no further command, so no mode write takes place.
- R5: In update mode, the block issues protection read (FCh) for each listed sector in index order and stores bits 7:0 of each response. It then issues unlock (E9h) with the password as data and polls status.
- R6: After the unlock, update mode issues write-enable, then bulk protection erase (E4h), then polls status. It then issues nothing, with busy held high, until updateDone is seen.
- R7: After updateDone, update mode issues write-enable, protection program (FDh) and status polling for each sector in index order whose stored byte was 00h, and skips the other sectors. It then issues write-enable, lock-bit clear (A6h) and status polling, and then raises done.
- R8: If POLL_LIMIT consecutive status responses in one poll report busy, the block raises error and issues no further command. POLL_LIMIT-1 busy responses followed by a clear one let the sequence continue.
- R9: The sector count is captured at start. A count above NUM_SECTORS is treated as NUM_SECTORS, and a count of zero skips every per-sector step.
- R10: While busy, the start input and sector register writes have no effect.
- R11: After reset, cmdValid, busy, done and error are low.
- R12: done and error stay high until the next start. That start clears them and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run when not busy |
| modeUpdate | input | 1 | 0 selects lockdown, 1 selects update; sampled with start |
| password | input | 64 | Password, captured at start |
| secWrEn | input | 1 | Sector register file write strobe |
| secWrIdx | input | IDX_W | Sector register file write index |
| secWrAddr | input | ADDR_W | Sector address to store |
| secCount | input | CNT_W | Number of listed sectors, captured at start |
| updateDone | input | 1 | Host signals that the array update has finished |
| rspValid | input | 1 | Response word valid for the pending read-type command |
| rspData | input | 64 | Response word |
| cmdValid | output | 1 | Command strobe |
| cmdOp | output | 8 | Command opcode |
| cmdAddr | output | ADDR_W | Command address |
| cmdData | output | 64 | Command data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run completed |
| error | output | 1 | Last run stopped on a mismatch or a poll timeout |

## Verification
The bench builds the block with four sector slots, 24-bit addresses and a poll limit of six. The small register file lets a requested count of seven show the clamp, and the three-bit count port still covers zero. The small poll limit brings both the timeout and the limit-minus-one boundary within a handful of status reads. The bench's device model supplies the busy responses, a corrupted password readback and a mix of 00h, FFh and 5Ah protection bytes. With these, the bench exercises the verify-before-commit rule and the selective restore.

// File: rtl/lockseq_pkg.sv
package lockseq_pkg;

  localparam logic [7:0] OP_WREN        = 8'h06;
  localparam logic [7:0] OP_STATUS      = 8'h05;
  localparam logic [7:0] OP_PROT_PROG   = 8'hFD;
  localparam logic [7:0] OP_PROT_READ   = 8'hFC;
  localparam logic [7:0] OP_PROT_ERASE  = 8'hE4;
  localparam logic [7:0] OP_PASS_PROG   = 8'hE8;
  localparam logic [7:0] OP_PASS_READ   = 8'hE7;
  localparam logic [7:0] OP_PASS_UNLOCK = 8'hE9;
  localparam logic [7:0] OP_MODE_WRITE  = 8'h2F;
  localparam logic [7:0] OP_LOCK_CLEAR  = 8'hA6;

  localparam logic [15:0] MODE_WORD = 16'hFFFB;

  typedef enum logic [1:0] {
    DATA_NONE,
    DATA_PASS,
    DATA_MODE
  } dataSel_e;

  // control -> datapath
  typedef struct packed {
    logic     capture;
    logic     idxClear;
    logic     idxInc;
    logic     saveProt;
    logic     pollClear;
    logic     pollInc;
    logic     useAddr;
    dataSel_e dataSel;
  } ctrlStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic noSectors;
    logic idxLast;
    logic curLocked;
    logic passMatch;
    logic pollExpired;
  } dpStatus_t;

endpackage

// File: rtl/lockseq_datapath.sv
module lockseq_datapath
  import lockseq_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int ADDR_W      = 32,
  parameter int PASS_W      = 64,
  parameter int POLL_LIMIT  = 4096,
  localparam int IDX_W  = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1,
  localparam int CNT_W  = $clog2(NUM_SECTORS + 1),
  localparam int POLL_W = $clog2(POLL_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic              allowWrite,
  input  logic              secWrEn,
  input  logic [IDX_W-1:0]  secWrIdx,
  input  logic [ADDR_W-1:0] secWrAddr,
  input  logic [CNT_W-1:0]  secCount,
  input  logic [PASS_W-1:0] password,
  input  logic [PASS_W-1:0] rspData,
  output dpStatus_t         stat,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [PASS_W-1:0] cmdData
);

  logic [ADDR_W-1:0] addrArr [NUM_SECTORS];
  logic [7:0]        protArr [NUM_SECTORS];

  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  cntReg;
  logic [PASS_W-1:0] passReg;
  logic [POLL_W-1:0] pollCnt;

  // one register slot per listed sector: address plus saved protection byte
  for (genvar g = 0; g < NUM_SECTORS; g++) begin : gEntry
    logic [ADDR_W-1:0] addrQ;
    logic [7:0]        protQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addrQ <= '0;
        protQ <= 8'hFF;
      end else begin
        if (allowWrite && secWrEn && secWrIdx == IDX_W'(g)) addrQ <= secWrAddr;
        if (strb.saveProt && idx == IDX_W'(g))             protQ <= rspData[7:0];
      end
    end
    assign addrArr[g] = addrQ;
    assign protArr[g] = protQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx     <= '0;
      cntReg  <= '0;
      passReg <= '0;
      pollCnt <= '0;
    end else begin
      if (strb.capture) begin
        passReg <= password;
        cntReg  <= (secCount > CNT_W'(NUM_SECTORS)) ? CNT_W'(NUM_SECTORS) : secCount;
      end
      if (strb.capture || strb.idxClear) idx <= '0;
      else if (strb.idxInc)              idx <= idx + 1'b1;
      if (strb.pollClear)    pollCnt <= '0;
      else if (strb.pollInc) pollCnt <= pollCnt + 1'b1;
    end
  end

  always_comb begin
    stat.noSectors   = (cntReg == '0);
    stat.idxLast     = (CNT_W'(idx) + CNT_W'(1)) == cntReg;
    stat.curLocked   = (protArr[idx] == 8'h00);
    stat.passMatch   = (rspData == passReg);
    stat.pollExpired = (pollCnt == POLL_W'(POLL_LIMIT - 1));
  end

  assign cmdAddr = strb.useAddr ? addrArr[idx] : '0;

  always_comb begin
    unique case (strb.dataSel)
      DATA_PASS: cmdData = passReg;
      DATA_MODE: cmdData = PASS_W'(MODE_WORD);
      default:   cmdData = '0;
    endcase
  end

endmodule

// File: rtl/lockseq_control.sv
module lockseq_control
  import lockseq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         modeUpdate,
  input  logic         updateDone,
  input  logic         rspValid,
  input  logic         rspWip,
  input  dpStatus_t    stat,
  output ctrlStrobes_t strb,
  output logic         cmdValid,
  output logic [7:0]   cmdOp,
  output logic         allowWrite,
  output logic         busy,
  output logic         done,
  output logic         error
);

  typedef enum logic [4:0] {
    S_IDLE, S_ARM,
    S_L_WREN, S_L_PROG,
    S_PW_WREN, S_PW_PROG, S_PW_READ, S_PW_WAIT,
    S_MD_WREN, S_MD_WRITE,
    S_U_READ, S_U_RWAIT, S_U_UNLOCK, S_U_EWREN, S_U_ERASE, S_U_HOLD,
    S_R_CHECK, S_R_WREN, S_R_PROG,
    S_C_WREN, S_C_CLEAR,
    S_POLL, S_POLL_WAIT,
    S_DONE, S_FAIL
  } state_e;

  typedef enum logic [2:0] {
    RET_LSEC, RET_PW, RET_MODE, RET_UNLOCK, RET_ERASE, RET_RSEC, RET_CLEAR
  } ret_e;

  state_e state, stateNext;
  ret_e   pollRet, retNext;
  logic   setRet;
  logic   modeReg;

  always_comb begin
    stateNext = state;
    strb      = '0;
    cmdValid  = 1'b0;
    cmdOp     = OP_WREN;
    setRet    = 1'b0;
    retNext   = RET_LSEC;
    unique case (state)
      S_IDLE, S_DONE, S_FAIL: begin
        if (start) begin
          strb.capture = 1'b1;
          stateNext    = S_ARM;
        end
      end
      S_ARM: begin
        if (modeReg) stateNext = stat.noSectors ? S_U_UNLOCK : S_U_READ;
        else         stateNext = stat.noSectors ? S_PW_WREN  : S_L_WREN;
      end
      // ---- lockdown ----
      S_L_WREN: begin
        cmdValid = 1'b1; cmdOp = OP_WREN; stateNext = S_L_PROG;
      end
      S_L_PROG: begin
        cmdValid = 1'b1; cmdOp = OP_PROT_PROG; strb.useAddr = 1'b1;
        strb.pollClear = 1'b1; setRet = 1'b1; retNext = RET_LSEC; stateNext = S_POLL;
      end
      S_PW_WREN: begin
        cmdValid = 1'b1; cmdOp = OP_WREN; stateNext = S_PW_PROG;
      end
      S_PW_PROG: begin
        cmdValid = 1'b1; cmdOp = OP_PASS_PROG; strb.dataSel = DATA_PASS;
        strb.pollClear = 1'b1; setRet = 1'b1; retNext = RET_PW; stateNext = S_POLL;
      end
      S_PW_READ: begin
        cmdValid = 1'b1; cmdOp = OP_PASS_READ; stateNext = S_PW_WAIT;
      end
      S_PW_WAIT: begin
        if (rspValid) stateNext = stat.passMatch ? S_MD_WREN : S_FAIL;
      end
      S_MD_WREN: begin
        cmdValid = 1'b1; cmdOp = OP_WREN; stateNext = S_MD_WRITE;
      end
      S_MD_WRITE: begin
        cmdValid = 1'b1; cmdOp = OP_MODE_WRITE; strb.dataSel = DATA_MODE;
        strb.pollClear = 1'b1; setRet = 1'b1; retNext = RET_MODE; stateNext = S_POLL;
      end
      // ---- update ----
      S_U_READ: begin
        cmdValid = 1'b1; cmdOp = OP_PROT_READ; strb.useAddr = 1'b1; stateNext = S_U_RWAIT;
      end
      S_U_RWAIT: begin
        if (rspValid) begin
          strb.saveProt = 1'b1;
          if (stat.idxLast) stateNext = S_U_UNLOCK;
          else begin
            strb.idxInc = 1'b1;
            stateNext   = S_U_READ;
          end
        end
      end
      S_U_UNLOCK: begin
        cmdValid = 1'b1; cmdOp = OP_PASS_UNLOCK; strb.dataSel = DATA_PASS;
        strb.pollClear = 1'b1; setRet = 1'b1; retNext = RET_UNLOCK; stateNext = S_POLL;
      end
      S_U_EWREN: begin
        cmdValid = 1'b1; cmdOp = OP_WREN; stateNext = S_U_ERASE;
      end
      S_U_ERASE: begin
        cmdValid = 1'b1; cmdOp = OP_PROT_ERASE;
        strb.pollClear = 1'b1; setRet = 1'b1; retNext = RET_ERASE; stateNext = S_POLL;
      end
      S_U_HOLD: begin
        if (updateDone) begin
          strb.idxClear = 1'b1;
          stateNext     = stat.noSectors ? S_C_WREN : S_R_CHECK;
        end
      end
      S_R_CHECK: begin
        if (stat.curLocked)    stateNext = S_R_WREN;
        else if (stat.idxLast) stateNext = S_C_WREN;
        else                   strb.idxInc = 1'b1;
      end
      S_R_WREN: begin
        cmdValid = 1'b1; cmdOp = OP_WREN; stateNext = S_R_PROG;
      end
      S_R_PROG: begin
        cmdValid = 1'b1; cmdOp = OP_PROT_PROG; strb.useAddr = 1'b1;
        strb.pollClear = 1'b1; setRet = 1'b1; retNext = RET_RSEC; stateNext = S_POLL;
      end
      S_C_WREN: begin
        cmdValid = 1'b1; cmdOp = OP_WREN; stateNext = S_C_CLEAR;
      end
      S_C_CLEAR: begin
        cmdValid = 1'b1; cmdOp = OP_LOCK_CLEAR;
        strb.pollClear = 1'b1; setRet = 1'b1; retNext = RET_CLEAR; stateNext = S_POLL;
      end
      // ---- shared busy polling ----
      S_POLL: begin
        cmdValid = 1'b1; cmdOp = OP_STATUS; stateNext = S_POLL_WAIT;
      end
      S_POLL_WAIT: begin
        if (rspValid) begin
          if (!rspWip) begin
            unique case (pollRet)
              RET_LSEC: begin
                if (stat.idxLast) stateNext = S_PW_WREN;
                else begin
                  strb.idxInc = 1'b1;
                  stateNext   = S_L_WREN;
                end
              end
              RET_PW:     stateNext = S_PW_READ;
              RET_MODE:   stateNext = S_DONE;
              RET_UNLOCK: stateNext = S_U_EWREN;
              RET_ERASE:  stateNext = S_U_HOLD;
              RET_RSEC: begin
                if (stat.idxLast) stateNext = S_C_WREN;
                else begin
                  strb.idxInc = 1'b1;
                  stateNext   = S_R_CHECK;
                end
              end
              default:    stateNext = S_DONE;
            endcase
          end else if (stat.pollExpired) begin
            stateNext = S_FAIL;
          end else begin
            strb.pollInc = 1'b1;
            stateNext    = S_POLL;
          end
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      pollRet <= RET_LSEC;
      modeReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (setRet)       pollRet <= retNext;
      if (strb.capture) modeReg <= modeUpdate;
    end
  end

  assign allowWrite = (state == S_IDLE) || (state == S_DONE) || (state == S_FAIL);
  assign busy       = !allowWrite;
  assign done       = (state == S_DONE);
  assign error      = (state == S_FAIL);

endmodule

// File: rtl/lockseq_top.sv
module lockseq_top
  import lockseq_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int ADDR_W      = 32,
  parameter int POLL_LIMIT  = 4096,
  localparam int IDX_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1,
  localparam int CNT_W = $clog2(NUM_SECTORS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              modeUpdate,
  input  logic [63:0]       password,
  input  logic              secWrEn,
  input  logic [IDX_W-1:0]  secWrIdx,
  input  logic [ADDR_W-1:0] secWrAddr,
  input  logic [CNT_W-1:0]  secCount,
  input  logic              updateDone,
  input  logic              rspValid,
  input  logic [63:0]       rspData,
  output logic              cmdValid,
  output logic [7:0]        cmdOp,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [63:0]       cmdData,
  output logic              busy,
  output logic              done,
  output logic              error
);

  ctrlStrobes_t strb;
  dpStatus_t    stat;
  logic         allowWrite;

  lockseq_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .modeUpdate (modeUpdate),
    .updateDone (updateDone),
    .rspValid   (rspValid),
    .rspWip     (rspData[0]),
    .stat       (stat),
    .strb       (strb),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .allowWrite (allowWrite),
    .busy       (busy),
    .done       (done),
    .error      (error)
  );

  lockseq_datapath #(
    .NUM_SECTORS (NUM_SECTORS),
    .ADDR_W      (ADDR_W),
    .PASS_W      (64),
    .POLL_LIMIT  (POLL_LIMIT)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .allowWrite (allowWrite),
    .secWrEn    (secWrEn),
    .secWrIdx   (secWrIdx),
    .secWrAddr  (secWrAddr),
    .secCount   (secCount),
    .password   (password),
    .rspData    (rspData),
    .stat       (stat),
    .cmdAddr    (cmdAddr),
    .cmdData    (cmdData)
  );

endmodule

// File: rtl/lockseq_checker.sv
module lockseq_checker
  import lockseq_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic [7:0]  cmdOp,
  input logic [63:0] cmdData,
  input logic        done,
  input logic        error
);

  logic isWrite;
  assign isWrite = cmdValid &&
    (cmdOp == OP_PROT_PROG || cmdOp == OP_PASS_PROG || cmdOp == OP_MODE_WRITE ||
     cmdOp == OP_PASS_UNLOCK || cmdOp == OP_PROT_ERASE || cmdOp == OP_LOCK_CLEAR);

  a_r1_prog_after_wren: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_PROT_PROG) |-> $past(cmdValid && cmdOp == OP_WREN));

  a_r1_write_then_status: assert property (@(posedge clk) disable iff (!rstN)
    isWrite |=> (cmdValid && cmdOp == OP_STATUS));

  a_r3_mode_after_wren: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_MODE_WRITE) |-> $past(cmdValid && cmdOp == OP_WREN));

  a_r3_mode_word: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_MODE_WRITE) |-> (cmdData == 64'h0000_0000_0000_FFFB));

  a_r6_erase_after_wren: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_PROT_ERASE) |-> $past(cmdValid && cmdOp == OP_WREN));

  a_r4_quiet_on_error: assert property (@(posedge clk) disable iff (!rstN)
    error |-> !cmdValid);

  a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

endmodule

bind lockseq_top lockseq_checker u_lockseqChk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .cmdData  (cmdData),
  .done     (done),
  .error    (error)
);

// File: tb/lockseq_top_bench.sv
`timescale 1ns/100ps
module lockseq_top_bench;
  import lockseq_pkg::*;

  localparam int NS = 4;
  localparam int AW = 24;
  localparam int PL = 6;
  localparam int IW = 2;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, modeUpdate = 1'b0, secWrEn = 1'b0, updateDone = 1'b0, rspValid = 1'b0;
  logic [63:0] password = '0, rspData = '0;
  logic [IW-1:0] secWrIdx = '0;
  logic [AW-1:0] secWrAddr = '0;
  logic [CW-1:0] secCount = '0;
  logic cmdValid, busy, done, error;
  logic [7:0] cmdOp;
  logic [AW-1:0] cmdAddr;
  logic [63:0] cmdData;

  always #2.5 clk = ~clk;

  lockseq_top #(.NUM_SECTORS(NS), .ADDR_W(AW), .POLL_LIMIT(PL)) u_lockseq_top (
    .clk(clk), .rstN(rstN), .start(start), .modeUpdate(modeUpdate), .password(password),
    .secWrEn(secWrEn), .secWrIdx(secWrIdx), .secWrAddr(secWrAddr), .secCount(secCount),
    .updateDone(updateDone), .rspValid(rspValid), .rspData(rspData),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .busy(busy), .done(done), .error(error));

  typedef struct {
    logic [7:0]    op;
    logic [AW-1:0] addr;
    logic [63:0]   data;
    string         req;
  } exp_t;

  exp_t expQ[$];
  int tests = 0, fails = 0;
  int busyCfg = 0, busyLeft = 0;
  bit corruptPw = 1'b0;
  bit pend = 1'b0;
  logic [63:0] pendData = '0;
  string curReq = "R11";
  logic [AW-1:0] secA [NS];
  logic [7:0]    protB [NS];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] protLookup(input logic [AW-1:0] a);
    for (int i = 0; i < NS; i++) if (secA[i] == a) return protB[i];
    return 8'hFF;
  endfunction

  function automatic bit isWriteOp(input logic [7:0] op);
    return op == OP_PROT_PROG || op == OP_PASS_PROG || op == OP_MODE_WRITE ||
           op == OP_PASS_UNLOCK || op == OP_PROT_ERASE || op == OP_LOCK_CLEAR;
  endfunction

  task automatic push(input logic [7:0] op, input logic [AW-1:0] a, input logic [63:0] d,
                      input string req);
    exp_t e;
    e.op = op; e.addr = a; e.data = d; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic expPoll(input int nBusy, input string req);
    int k;
    k = (nBusy >= PL) ? PL : nBusy + 1;
    for (int i = 0; i < k; i++) push(OP_STATUS, '0, '0, req);
  endtask

  task automatic expLockdown(input int n, input int nBusy, input bit bad);
    for (int i = 0; i < n; i++) begin
      push(OP_WREN, '0, '0, "R1");
      push(OP_PROT_PROG, secA[i], '0, "R1");
      expPoll(nBusy, "R1");
    end
    push(OP_WREN, '0, '0, "R2");
    push(OP_PASS_PROG, '0, password, "R2");
    expPoll(nBusy, "R2");
    push(OP_PASS_READ, '0, '0, "R2");
    if (!bad) begin
      push(OP_WREN, '0, '0, "R3");
      push(OP_MODE_WRITE, '0, 64'hFFFB, "R3");
      expPoll(nBusy, "R3");
    end
  endtask

  // device model and per-clock comparison of the command stream
  initial begin
    forever begin
      @(negedge clk);
      rspValid = pend;
      rspData  = pendData;
      pend     = 1'b0;
      if (rstN && cmdValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, curReq, "unexpected command opcode", {56'h0, cmdOp}, 64'h0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          tests++;
          if (cmdOp !== e.op || cmdAddr !== e.addr || cmdData !== e.data) begin
            fails++;
            $display("FAIL %s command actual=%h/%h/%h expected=%h/%h/%h", e.req,
                     cmdOp, cmdAddr, cmdData, e.op, e.addr, e.data);
          end
        end
        if (isWriteOp(cmdOp)) busyLeft = busyCfg;
        if (cmdOp == OP_STATUS) begin
          pend = 1'b1;
          pendData = (busyLeft > 0) ? 64'd1 : 64'd0;
          if (busyLeft > 0) busyLeft--;
        end else if (cmdOp == OP_PASS_READ) begin
          pend = 1'b1;
          pendData = corruptPw ? (password ^ 64'h1) : password;
        end else if (cmdOp == OP_PROT_READ) begin
          pend = 1'b1;
          pendData = {56'h0, protLookup(cmdAddr)};
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog expired actual=%0d expected=0", 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic pulseStart(input bit mode, input int cnt);
    @(negedge clk);
    modeUpdate = mode; secCount = CW'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitEnd(input string req);
    int n;
    n = 0;
    while (!(done || error) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(expQ.size() == 0, req, "expected commands left", 64'(expQ.size()), 64'd0);
    expQ.delete();
  endtask

  task automatic waitDrain();
    int n;
    n = 0;
    while (expQ.size() != 0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    secA[0] = 24'h010000; secA[1] = 24'h020000; secA[2] = 24'h030000; secA[3] = 24'h040000;
    protB[0] = 8'h00; protB[1] = 8'hFF; protB[2] = 8'h00; protB[3] = 8'h5A;
    repeat (4) @(negedge clk);
    check(cmdValid == 1'b0, "R11", "cmdValid in reset", 64'(cmdValid), 64'd0);
    check({busy, done, error} == 3'b000, "R11", "flags in reset", 64'({busy, done, error}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, done, error} == 3'b000, "R11", "flags after reset", 64'({busy, done, error}), 64'd0);

    for (int i = 0; i < NS; i++) begin
      @(negedge clk);
      secWrEn = 1'b1; secWrIdx = IW'(i); secWrAddr = secA[i];
    end
    @(negedge clk);
    secWrEn = 1'b0;

    // lockdown over three sectors, two busy polls each (R1 R2 R3)
    curReq = "R1";
    password = 64'h0123_4567_89AB_CDEF;
    busyCfg = 2;
    expLockdown(3, 2, 1'b0);
    pulseStart(1'b0, 3);
    waitEnd("R3");
    check(done == 1'b1 && error == 1'b0, "R3", "done after lockdown", 64'({done, error}), 64'b10);
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R12", "done held", 64'(done), 64'd1);

    // readback mismatch (R4) and flag clearing on new start (R12)
    curReq = "R4";
    corruptPw = 1'b1;
    busyCfg = 0;
    expLockdown(1, 0, 1'b1);
    pulseStart(1'b0, 1);
    check(done == 1'b0, "R12", "done cleared by start", 64'(done), 64'd0);
    waitEnd("R4");
    check(error == 1'b1 && done == 1'b0, "R4", "error on mismatch", 64'({done, error}), 64'b01);
    repeat (20) @(negedge clk);
    check(error == 1'b1, "R12", "error held", 64'(error), 64'd1);
    corruptPw = 1'b0;

    // update over four sectors (R5 R6 R7), start and sector write while busy (R10)
    curReq = "R6";
    password = 64'hFEDC_BA98_7654_3210;
    busyCfg = 1;
    for (int i = 0; i < NS; i++) push(OP_PROT_READ, secA[i], '0, "R5");
    push(OP_PASS_UNLOCK, '0, password, "R5");
    expPoll(1, "R5");
    push(OP_WREN, '0, '0, "R6");
    push(OP_PROT_ERASE, '0, '0, "R6");
    expPoll(1, "R6");
    pulseStart(1'b1, 4);
    check(error == 1'b0, "R12", "error cleared by start", 64'(error), 64'd0);
    waitDrain();
    repeat (6) @(negedge clk);
    check(busy == 1'b1 && done == 1'b0, "R6", "holding for update", 64'({busy, done}), 64'b10);
    curReq = "R10";
    @(negedge clk);
    start = 1'b1; modeUpdate = 1'b0; secWrEn = 1'b1; secWrIdx = '0; secWrAddr = 24'h0AA000;
    @(negedge clk);
    start = 1'b0; secWrEn = 1'b0;
    repeat (6) @(negedge clk);
    check(busy == 1'b1, "R10", "start while busy ignored", 64'(busy), 64'd1);
    curReq = "R7";
    push(OP_WREN, '0, '0, "R7");
    push(OP_PROT_PROG, secA[0], '0, "R10");
    expPoll(1, "R7");
    push(OP_WREN, '0, '0, "R7");
    push(OP_PROT_PROG, secA[2], '0, "R7");
    expPoll(1, "R7");
    push(OP_WREN, '0, '0, "R7");
    push(OP_LOCK_CLEAR, '0, '0, "R7");
    expPoll(1, "R7");
    @(negedge clk); updateDone = 1'b1;
    @(negedge clk); updateDone = 1'b0;
    waitEnd("R7");
    check(done == 1'b1 && error == 1'b0, "R7", "done after update", 64'({done, error}), 64'b10);

    // poll timeout (R8)
    curReq = "R8";
    busyCfg = PL;
    push(OP_WREN, '0, '0, "R8");
    push(OP_PROT_PROG, secA[0], '0, "R8");
    expPoll(PL, "R8");
    pulseStart(1'b0, 1);
    waitEnd("R8");
    check(error == 1'b1, "R8", "error on poll timeout", 64'(error), 64'd1);
    repeat (10) @(negedge clk);

    // one busy response below the limit still proceeds (R8)
    busyCfg = PL - 1;
    expLockdown(1, PL - 1, 1'b0);
    pulseStart(1'b0, 1);
    waitEnd("R8");
    check(done == 1'b1 && error == 1'b0, "R8", "limit minus one proceeds", 64'({done, error}), 64'b10);

    // count clamp (R9)
    curReq = "R9";
    busyCfg = 0;
    expLockdown(NS, 0, 1'b0);
    pulseStart(1'b0, 7);
    waitEnd("R9");
    check(done == 1'b1, "R9", "clamped count done", 64'(done), 64'd1);

    // zero sectors in update mode (R9)
    push(OP_PASS_UNLOCK, '0, password, "R9");
    expPoll(0, "R9");
    push(OP_WREN, '0, '0, "R9");
    push(OP_PROT_ERASE, '0, '0, "R9");
    expPoll(0, "R9");
    pulseStart(1'b1, 0);
    waitDrain();
    repeat (4) @(negedge clk);
    push(OP_WREN, '0, '0, "R9");
    push(OP_LOCK_CLEAR, '0, '0, "R9");
    expPoll(0, "R9");
    @(negedge clk); updateDone = 1'b1;
    @(negedge clk); updateDone = 1'b0;
    waitEnd("R9");
    check(done == 1'b1, "R9", "zero-count update done", 64'(done), 64'd1);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule